// File: doc/BRIEF.md
# Byte Read-Modify-Write Sequencer

This block carries out the byte-sized logic instructions whose operand is in memory. A one-cycle start pulse hands it the 16-bit instruction word, the current base and index register values, the value of the pointer register and the current T flag. The block decodes the instruction and forms the byte address. It reads the byte over a request/acknowledge memory port, combines it with the 8-bit immediate held in the instruction, and writes the result back when the operation requires a write. It also produces the new T flag.

Four forms take the immediate and address memory at base plus index: AND, OR, XOR and a test. A fifth form, test-and-set, addresses memory through the pointer register. It checks the fetched byte for zero and writes it back with its top bit set. A lock output holds the bus from the read through the write, so the check and the set cannot be split by another master. Wait states on the memory port lengthen the sequence but leave its result unchanged.

Top module: `byte_rmw_seq`

## Requirements
- R1: Decoding uses the instruction's top byte: 0xCD is AND, 0xCF is OR, 0xCE is XOR, 0xCC is test. For these four, the immediate is bits 7:0 and the byte address is `r0_i + gbr_i` modulo 2^32. A word with bits 15:12 = 0x4 and bits 7:0 = 0x1B is test-and-set, and its address is `rn_i`.
- R2: AND, OR and XOR read the addressed byte, combine it bitwise with the immediate, and write the result back to the same address. `t_o` then equals the `t_i` value captured with the start.
- R3: The test form reads the byte and sets `t_o` to 1 exactly when the byte ANDed with the immediate is zero. It makes no write access.
- R4: Test-and-set sets `t_o` to 1 exactly when the fetched byte is zero. It then writes the byte back with bit 7 forced to 1.
- R5: With a memory that acknowledges in the cycle of the request, `busy_o` is high for 3 cycles for AND, OR, XOR and the test, and for 4 cycles for test-and-set, starting the cycle after the start pulse.
- R6: A memory request keeps its address, write enable and write data stable until it is acknowledged. Each wait cycle adds exactly one cycle to the sequence.
- R7: `mem_lock_o` is high in every busy cycle of test-and-set except the last. This covers both of its accesses. It is never high for any other form.
- R8: `done_o` is a single-cycle pulse in the final busy cycle, after the last access has been acknowledged. `busy_o` is low in the next cycle.
- R9: A start pulse while busy, or with an instruction word that R1 does not recognize, is ignored. No memory access results and no sequence starts.
- R10: After reset the block is idle: `busy_o`, `done_o`, `mem_req_o`, `mem_we_o` and `mem_lock_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle command strobe |
| insn_i | input | 16 | Instruction word |
| r0_i | input | 32 | Index register value |
| gbr_i | input | 32 | Base register value |
| rn_i | input | 32 | Pointer register value for test-and-set |
| t_i | input | 1 | Current T flag |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Completion pulse |
| t_o | output | 1 | Updated T flag |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access acknowledge |
| mem_lock_o | output | 1 | Bus lock for the atomic form |

## Verification
Each logic form is tried with a memory byte and immediate chosen so that AND, OR and XOR produce results distinct from each other. This catches a swapped operation. The test form is run once with overlapping bits and once with disjoint bits, which separates the two T outcomes. Test-and-set is run once on a zero byte and once on a non-zero byte, which separates the T result from the forced top bit. The address is exercised three ways: a base plus index sum that wraps past 2^32, a sum with high bits set, and the pointer path. Zero-wait and wait-state runs tell the fixed cycle budget apart from stretching by acknowledge delay. Two more runs check that a start during a sequence and an unrecognized instruction word both leave memory untouched.

// File: rtl/brmw_pkg.sv
package brmw_pkg;

    localparam int BYTE_W = 8;
    localparam int INSN_W = 16;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_AND  = 3'd1,
        OP_OR   = 3'd2,
        OP_XOR  = 3'd3,
        OP_TST  = 3'd4,
        OP_TAS  = 3'd5
    } brmw_op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_HOLD  = 3'd2,
        ST_WRITE = 3'd3,
        ST_FIN   = 3'd4
    } brmw_st_e;

endpackage

// File: rtl/brmw_decode.sv
module brmw_decode
    import brmw_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output brmw_op_e          op_o,
    output logic [BYTE_W-1:0] imm_o
);
    always_comb begin
        imm_o = insn_i[7:0];
        unique case (insn_i[15:8])
            8'hCD:   op_o = OP_AND;
            8'hCF:   op_o = OP_OR;
            8'hCE:   op_o = OP_XOR;
            8'hCC:   op_o = OP_TST;
            default: op_o = (insn_i[15:12] == 4'h4 && insn_i[7:0] == 8'h1B)
                            ? OP_TAS : OP_NONE;
        endcase
    end
endmodule

// File: rtl/brmw_agen.sv
module brmw_agen
    import brmw_pkg::*;
#(
    parameter int AW = 32
) (
    input  brmw_op_e      op_i,
    input  logic [AW-1:0] r0_i,
    input  logic [AW-1:0] gbr_i,
    input  logic [AW-1:0] rn_i,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] sum;

    always_comb begin
        sum    = r0_i + gbr_i;
        addr_o = (op_i == OP_TAS) ? rn_i : sum;
    end
endmodule

// File: rtl/brmw_alu.sv
module brmw_alu
    import brmw_pkg::*;
(
    input  brmw_op_e          op_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic [BYTE_W-1:0] imm_i,
    output logic [BYTE_W-1:0] result_o,
    output logic              t_new_o,
    output logic              t_upd_o
);
    always_comb begin
        result_o = data_i;
        t_new_o  = 1'b0;
        t_upd_o  = 1'b0;
        unique case (op_i)
            OP_AND: result_o = data_i & imm_i;
            OP_OR:  result_o = data_i | imm_i;
            OP_XOR: result_o = data_i ^ imm_i;
            OP_TST: begin
                t_new_o = ((data_i & imm_i) == '0);
                t_upd_o = 1'b1;
            end
            OP_TAS: begin
                result_o[BYTE_W-1] = 1'b1;
                t_new_o = (data_i == '0);
                t_upd_o = 1'b1;
            end
            default: result_o = data_i;
        endcase
    end
endmodule

// File: rtl/byte_rmw_seq.sv
module byte_rmw_seq
    import brmw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [AW-1:0]     r0_i,
    input  logic [AW-1:0]     gbr_i,
    input  logic [AW-1:0]     rn_i,
    input  logic              t_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              t_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              mem_lock_o
);
    typedef struct packed {
        brmw_st_e          st;
        brmw_op_e          op;
        logic [AW-1:0]     addr;
        logic [BYTE_W-1:0] imm;
        logic [BYTE_W-1:0] rbyte;
        logic              t;
    } seq_regs_t;

    seq_regs_t q, d;

    brmw_op_e          dec_op;
    logic [BYTE_W-1:0] dec_imm;
    logic [AW-1:0]     ea;
    logic [BYTE_W-1:0] alu_res;
    logic              alu_t, alu_tupd;
    logic              is_tas;

    brmw_decode u_dec (
        .insn_i (insn_i),
        .op_o   (dec_op),
        .imm_o  (dec_imm)
    );

    brmw_agen #(.AW(AW)) u_agen (
        .op_i   (dec_op),
        .r0_i   (r0_i),
        .gbr_i  (gbr_i),
        .rn_i   (rn_i),
        .addr_o (ea)
    );

    brmw_alu u_alu (
        .op_i     (q.op),
        .data_i   (q.rbyte),
        .imm_i    (q.imm),
        .result_o (alu_res),
        .t_new_o  (alu_t),
        .t_upd_o  (alu_tupd)
    );

    assign is_tas = (q.op == OP_TAS);

    always_comb begin
        d          = q;
        mem_req_o  = 1'b0;
        mem_we_o   = 1'b0;
        mem_lock_o = 1'b0;
        done_o     = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i && dec_op != OP_NONE) begin
                    d.st   = ST_READ;
                    d.op   = dec_op;
                    d.addr = ea;
                    d.imm  = dec_imm;
                    d.t    = t_i;
                end
            end
            ST_READ: begin
                mem_req_o  = 1'b1;
                mem_lock_o = is_tas;
                if (mem_ack_i) begin
                    d.rbyte = mem_rdata_i;
                    d.st    = (q.op == OP_TST || is_tas) ? ST_HOLD : ST_WRITE;
                end
            end
            ST_HOLD: begin
                mem_lock_o = is_tas;
                if (alu_tupd) d.t = alu_t;
                d.st = is_tas ? ST_WRITE : ST_FIN;
            end
            ST_WRITE: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_lock_o = is_tas;
                if (mem_ack_i) d.st = ST_FIN;
            end
            ST_FIN: begin
                done_o = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.op    <= OP_NONE;
            q.addr  <= '0;
            q.imm   <= '0;
            q.rbyte <= '0;
            q.t     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy_o      = (q.st != ST_IDLE);
    assign t_o         = q.t;
    assign mem_addr_o  = q.addr;
    assign mem_wdata_o = alu_res;

    // R6: an unanswered request keeps its attributes
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(mem_wdata_o));

    // R7: lock only inside a sequence, and every test-and-set write is locked
    a_r7_lock_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_lock_o |-> busy_o && !done_o);
    a_r7_lock_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o && q.op == OP_TAS |-> mem_lock_o);

    // R8: done is one cycle wide and returns the block to idle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);
    a_r8_done_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o);

    // R3: the test form never writes
    a_r3_tst_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && q.op == OP_TST |-> !mem_we_o);

    // R9: the operation in flight is not replaced by a new start
    a_r9_op_kept: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o |=> $stable(q.op) && $stable(mem_addr_o));

    // R10: idle after reset
    a_r10_idle: assert property (@(posedge clk)
        !rst_n |=> !busy_o && !mem_req_o && !mem_lock_o);
endmodule

// File: tb/byte_rmw_seq_test.sv
module byte_rmw_seq_test;
    import brmw_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] insn_i = '0;
    logic [31:0] r0_i = '0, gbr_i = '0, rn_i = '0;
    logic        t_i = 1'b0;
    logic        busy_o, done_o, t_o;
    logic        mem_req_o, mem_we_o, mem_lock_o, mem_ack_i;
    logic [31:0] mem_addr_o;
    logic [7:0]  mem_wdata_o, mem_rdata_i;

    int checks = 0, errors = 0;
    int waits = 0, wcnt = 0;
    logic [7:0] mem [0:255];
    int n_rd = 0, n_wr = 0, n_lock_cyc = 0, n_lock_acc = 0;
    logic [31:0] last_raddr = '0, last_waddr = '0;
    int cyc, ndone;

    always #2 clk = ~clk;

    byte_rmw_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
        .r0_i(r0_i), .gbr_i(gbr_i), .rn_i(rn_i), .t_i(t_i),
        .busy_o(busy_o), .done_o(done_o), .t_o(t_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .mem_ack_i(mem_ack_i), .mem_lock_o(mem_lock_o)
    );

    assign mem_ack_i   = mem_req_o && (wcnt == waits);
    assign mem_rdata_i = mem[mem_addr_o[7:0]];

    always @(posedge clk) begin
        if (mem_req_o && !mem_ack_i) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (mem_lock_o) n_lock_cyc <= n_lock_cyc + 1;
        if (mem_req_o && mem_ack_i) begin
            if (mem_lock_o) n_lock_acc <= n_lock_acc + 1;
            if (mem_we_o) begin
                mem[mem_addr_o[7:0]] <= mem_wdata_o;
                n_wr <= n_wr + 1;
                last_waddr <= mem_addr_o;
            end else begin
                n_rd <= n_rd + 1;
                last_raddr <= mem_addr_o;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Pulse start, then count busy cycles and done pulses until done is seen
    task automatic run(input logic [15:0] insn, input logic [31:0] r0,
                       input logic [31:0] gbr, input logic [31:0] rn,
                       input logic tin, input int w);
        logic seen;
        @(negedge clk);
        waits = w; insn_i = insn; r0_i = r0; gbr_i = gbr; rn_i = rn; t_i = tin;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        t_i = ~tin;
        cyc = 0; ndone = 0; seen = 1'b0;
        for (int g = 0; g < 100 && !seen; g++) begin
            if (busy_o) cyc++;
            if (done_o) begin ndone++; seen = 1'b1; end
            @(negedge clk);
        end
        chk(!busy_o && !done_o, "R8 idle after done", {30'd0, busy_o, done_o}, 0);
        chk(ndone == 1, "R8 one done pulse", ndone, 1);
    endtask

    task automatic t_reset;
        chk(!busy_o && !done_o && !mem_req_o && !mem_we_o && !mem_lock_o,
            "R10 reset idle",
            {27'd0, busy_o, done_o, mem_req_o, mem_we_o, mem_lock_o}, 0);
    endtask

    task automatic t_and;
        int wr0 = n_wr, lk0 = n_lock_cyc;
        mem[8'h34] = 8'hF0;
        run(16'hCD3C, 32'h30, 32'h04, 32'h0, 1'b1, 0);
        chk(mem[8'h34] == 8'h30, "R2 AND result", mem[8'h34], 8'h30);
        chk(last_waddr == 32'h34, "R1 AND address", last_waddr, 32'h34);
        chk(n_wr - wr0 == 1, "R2 AND one write", n_wr - wr0, 1);
        chk(t_o == 1'b1, "R2 AND keeps T", t_o, 1);
        chk(cyc == 3, "R5 AND cycles", cyc, 3);
        chk(n_lock_cyc == lk0, "R7 AND no lock", n_lock_cyc - lk0, 0);
    endtask

    task automatic t_or;
        mem[8'h41] = 8'h0A;
        run(16'hCF50, 32'h1000_0040, 32'h1, 32'h0, 1'b0, 0);
        chk(mem[8'h41] == 8'h5A, "R2 OR result", mem[8'h41], 8'h5A);
        chk(last_raddr == 32'h1000_0041, "R1 OR address", last_raddr, 32'h1000_0041);
        chk(t_o == 1'b0, "R2 OR keeps T", t_o, 0);
    endtask

    task automatic t_xor_wait;
        mem[8'h15] = 8'h3C;
        run(16'hCEFF, 32'hFFFF_FFF0, 32'h25, 32'h0, 1'b1, 2);
        chk(mem[8'h15] == 8'hC3, "R2 XOR result", mem[8'h15], 8'hC3);
        chk(last_waddr == 32'h15, "R1 wrapped address", last_waddr, 32'h15);
        chk(cyc == 7, "R6 XOR with two waits", cyc, 7);
    endtask

    task automatic t_tst;
        int wr0 = n_wr;
        mem[8'h60] = 8'h0F;
        run(16'hCCF0, 32'h60, 32'h0, 32'h0, 1'b0, 0);
        chk(t_o == 1'b1, "R3 TST zero sets T", t_o, 1);
        chk(cyc == 3, "R5 TST cycles", cyc, 3);
        run(16'hCC08, 32'h20, 32'h40, 32'h0, 1'b1, 0);
        chk(t_o == 1'b0, "R3 TST nonzero clears T", t_o, 0);
        chk(n_wr == wr0, "R3 TST no write", n_wr - wr0, 0);
        chk(mem[8'h60] == 8'h0F, "R3 TST memory kept", mem[8'h60], 8'h0F);
    endtask

    task automatic t_tas;
        int lk0 = n_lock_cyc, la0 = n_lock_acc;
        mem[8'h80] = 8'h00;
        run(16'h431B, 32'hFF, 32'hFF, 32'h80, 1'b0, 0);
        chk(t_o == 1'b1, "R4 TAS zero sets T", t_o, 1);
        chk(mem[8'h80] == 8'h80, "R4 TAS sets bit 7", mem[8'h80], 8'h80);
        chk(last_waddr == 32'h80, "R1 TAS address from rn", last_waddr, 32'h80);
        chk(cyc == 4, "R5 TAS cycles", cyc, 4);
        chk(n_lock_acc - la0 == 2, "R7 TAS accesses locked", n_lock_acc - la0, 2);
        chk(n_lock_cyc - lk0 == 3, "R7 TAS lock span", n_lock_cyc - lk0, 3);
        lk0 = n_lock_cyc;
        mem[8'h90] = 8'h05;
        run(16'h471B, 32'h0, 32'h0, 32'h90, 1'b1, 1);
        chk(t_o == 1'b0, "R4 TAS nonzero clears T", t_o, 0);
        chk(mem[8'h90] == 8'h85, "R4 TAS nonzero write", mem[8'h90], 8'h85);
        chk(cyc == 6, "R6 TAS with one wait", cyc, 6);
        chk(n_lock_cyc - lk0 == 5, "R7 TAS lock span with waits", n_lock_cyc - lk0, 5);
    endtask

    task automatic t_bad_insn;
        int rd0 = n_rd;
        logic any_busy = 1'b0;
        @(negedge clk);
        insn_i = 16'hCB12; r0_i = 32'h10; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            any_busy |= busy_o;
            @(negedge clk);
        end
        chk(!any_busy, "R9 unknown insn ignored", any_busy, 0);
        chk(n_rd == rd0, "R9 unknown insn no access", n_rd - rd0, 0);
    endtask

    task automatic t_busy_start;
        int wr0 = n_wr;
        logic any_busy = 1'b0;
        mem[8'h50] = 8'hFF;
        mem[8'h70] = 8'h11;
        waits = 1;
        @(negedge clk);
        insn_i = 16'hCD0F; r0_i = 32'h50; gbr_i = 32'h0; start_i = 1'b1;
        @(negedge clk);
        insn_i = 16'hCEFF; r0_i = 32'h70;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 12; i++) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            any_busy |= busy_o;
            @(negedge clk);
        end
        chk(mem[8'h50] == 8'h0F, "R9 first op completes", mem[8'h50], 8'h0F);
        chk(mem[8'h70] == 8'h11, "R9 start while busy ignored", mem[8'h70], 8'h11);
        chk(n_wr - wr0 == 1, "R9 single write", n_wr - wr0, 1);
        chk(!any_busy, "R9 no second sequence", any_busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_and();
        t_or();
        t_xor_wait();
        t_tst();
        t_tas();
        t_bad_insn();
        t_busy_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule